// File: doc/BRIEF.md
# ULPI PHY pin guard and start-up sequencer

This block sits on the PHY side of a ULPI link and decides, cycle by cycle, who may drive the interface pins and which weak pulls are switched on. It holds DIR high while the PHY is in reset. Once reset is released it lowers DIR after a fixed number of clock cycles. It also tri-states every PHY-driven pin and asks the rest of the chip to power down when the chip-select/power-down input is high.

It also guards the bus against a link that is not yet driving it. A weak pull-up on the STP pad makes an undriven STP read high. When STP is seen high while the PHY does not own the bus and no transfer is in progress, the block turns on weak pull-downs on all DATA lines. A configuration bit turns this protection off, together with the STP pull-up, to save power.

The reset release and STP are brought into the clock domain through a synchronizer chain before use. Leaving power-down replays the same DIR-high start-up sequence as leaving reset. After start-up, DIR and the DATA output enable follow the turnaround request from the PHY datapath.

Top module: `ulpi_guard_ctrl`

## Requirements
- R1: While `rst_n_i` is low (and `csel_pd_i` low), `dir_o`=1, `dir_oe_o`=1, `nxt_oe_o`=1, `data_oe_o`=0, `stp_pu_en_o`=1, `data_pd_en_o`=0 and `pd_req_o`=0, whatever STP does.
- R2: After `rst_n_i` rises between two clock edges, `dir_o` stays 1 through the first three rising edges and is 0 after the fourth, given `phy_turn_i`=0.
- R3: Reset returns the protection-disable bit to 0, so `stp_pu_en_o` is 1 again at once when `rst_n_i` goes low, even if the bit was set.
- R4: With the protection-disable bit 0 and `csel_pd_i` low, `stp_pu_en_o` is 1.
- R5: STP passes through two flops. When that sampled STP is 1, `dir_o` is 0, `xfer_en_i` is 0 and protection is enabled, all eight bits of `data_pd_en_o` are 1. In every other case all eight bits are 0, and no partial pattern ever appears.
- R6: The DATA pull-downs go off after the second rising edge at which `stp_i` is low, which is the first edge at which the sampled STP is low.
- R7: A write (`cfg_we_i`=1, `cfg_wdat_i`=1) sets the protection-disable bit at that edge. From then on `stp_pu_en_o` and `data_pd_en_o` are 0. Writing 0 turns protection back on.
- R8: While `csel_pd_i` is 1, `dir_oe_o`, `nxt_oe_o` and `data_oe_o` are 0, both pull enables are 0 and `pd_req_o` is 1. This holds combinationally, without waiting for a clock.
- R9: When `csel_pd_i` falls, `dir_o` is 1 and `dir_oe_o` is 1. DIR then falls after the fourth rising edge, exactly as in R2.
- R10: After start-up, `dir_o` equals `phy_turn_i`, and `data_oe_o` is 1 exactly when `phy_turn_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | ULPI interface clock |
| rst_n_i | input | 1 | Asynchronous active-low reset pin |
| csel_pd_i | input | 1 | Chip deselect / power-down pin, high = powered down |
| stp_i | input | 1 | STP pad level as received |
| xfer_en_i | input | 1 | Link-side datapath reports a valid transfer phase |
| phy_turn_i | input | 1 | PHY datapath requests ownership of the bus |
| cfg_we_i | input | 1 | Write strobe for the protection-disable bit |
| cfg_wdat_i | input | 1 | Value written to the protection-disable bit |
| dir_o | output | 1 | DIR level |
| dir_oe_o | output | 1 | Output enable of the DIR pad |
| nxt_oe_o | output | 1 | Output enable of the NXT pad |
| data_oe_o | output | 1 | Output enable of the DATA pads |
| stp_pu_en_o | output | 1 | Weak pull-up enable on STP |
| data_pd_en_o | output | 8 | Weak pull-down enables, one per DATA line |
| pd_req_o | output | 1 | Power-down request to internal circuitry |

## Verification
Directed sequences cover several cases. The bench counts DIR edge by edge after reset release and after power-down exit, which separates a four-cycle release from a three- or five-cycle one. It raises and lowers STP and checks the pull-downs one and two edges later, which confirms the synchronizer depth in both directions. It also checks the pull-downs while DIR or a transfer phase should block them. A random phase then mixes STP, transfer-enable, turnaround and protection-disable writes. This shows whether each gating term is present and whether a written bit takes effect at the right edge.

// File: rtl/ulpi_gd_pkg.sv
package ulpi_gd_pkg;

   localparam int unsigned DEF_DATA_W       = 8;
   localparam int unsigned DEF_SYNC_STAGES  = 2;
   localparam int unsigned DEF_DIR_HOLD_CYC = 4;

   // output enables for the PHY-driven pads
   typedef struct packed {
      logic dir_oe;
      logic nxt_oe;
      logic data_oe;
   } pad_drv_t;

endpackage

// File: rtl/ulpi_gd_sync.sv
module ulpi_gd_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic arst_n_i,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge arst_n_i) begin
               if (!arst_n_i) chain_q[0] <= 1'b0;
               else           chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge arst_n_i) begin
               if (!arst_n_i) chain_q[s] <= 1'b0;
               else           chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ulpi_gd_dir_seq.sv
module ulpi_gd_dir_seq #(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned DIR_HOLD_CYC = 4
) (
   input  logic clk_i,
   input  logic arst_n_i,
   output logic boot_o
);
   localparam int unsigned CNT_INIT = DIR_HOLD_CYC - SYNC_STAGES;
   localparam int unsigned CNT_W    = (CNT_INIT < 2) ? 1 : $clog2(CNT_INIT + 1);

   logic             ready;
   logic [CNT_W-1:0] hold_cnt_q;

   ulpi_gd_sync #(.STAGES(SYNC_STAGES)) u_rel_sync (
      .clk_i   (clk_i),
      .arst_n_i(arst_n_i),
      .d_i     (1'b1),
      .q_o     (ready)
   );

   always_ff @(posedge clk_i or negedge arst_n_i) begin
      if (!arst_n_i)
         hold_cnt_q <= CNT_W'(CNT_INIT);
      else if (ready && (hold_cnt_q != '0))
         hold_cnt_q <= hold_cnt_q - CNT_W'(1);
   end

   assign boot_o = !ready || (hold_cnt_q != '0);
endmodule

// File: rtl/ulpi_gd_prot.sv
module ulpi_gd_prot #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              cfg_we_i,
   input  logic              cfg_wdat_i,
   input  logic              stp_smp_i,
   input  logic              dir_lvl_i,
   input  logic              xfer_en_i,
   input  logic              pd_i,
   output logic              stp_pu_en_o,
   output logic [DATA_W-1:0] data_pd_en_o
);
   logic prot_off_q;
   logic guard_hit;

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)      prot_off_q <= 1'b0;
      else if (cfg_we_i) prot_off_q <= cfg_wdat_i;
   end

   assign stp_pu_en_o = !pd_i && !prot_off_q;
   assign guard_hit   = stp_pu_en_o && stp_smp_i && !dir_lvl_i && !xfer_en_i;

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_lane
         assign data_pd_en_o[b] = guard_hit;
      end
   endgenerate
endmodule

// File: rtl/ulpi_guard_ctrl.sv
module ulpi_guard_ctrl
   import ulpi_gd_pkg::*;
#(
   parameter int unsigned DATA_W       = DEF_DATA_W,
   parameter int unsigned SYNC_STAGES  = DEF_SYNC_STAGES,
   parameter int unsigned DIR_HOLD_CYC = DEF_DIR_HOLD_CYC
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              csel_pd_i,
   input  logic              stp_i,
   input  logic              xfer_en_i,
   input  logic              phy_turn_i,
   input  logic              cfg_we_i,
   input  logic              cfg_wdat_i,
   output logic              dir_o,
   output logic              dir_oe_o,
   output logic              nxt_oe_o,
   output logic              data_oe_o,
   output logic              stp_pu_en_o,
   output logic [DATA_W-1:0] data_pd_en_o,
   output logic              pd_req_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ulpi_guard_ctrl: SYNC_STAGES must be at least 2");
      end
      if (DIR_HOLD_CYC < 4 || DIR_HOLD_CYC > 5 || DIR_HOLD_CYC <= SYNC_STAGES) begin : g_bad_hold
         $error("ulpi_guard_ctrl: DIR_HOLD_CYC must be 4 or 5 and exceed SYNC_STAGES");
      end
      if (DATA_W == 0) begin : g_bad_w
         $error("ulpi_guard_ctrl: DATA_W must be non-zero");
      end
   endgenerate

   logic     seq_arst_n;
   logic     boot;
   logic     stp_smp;
   logic     dir_lvl;
   pad_drv_t drv;

   // power-down restarts the start-up sequence exactly like reset
   assign seq_arst_n = rst_n_i && !csel_pd_i;

   ulpi_gd_dir_seq #(
      .SYNC_STAGES (SYNC_STAGES),
      .DIR_HOLD_CYC(DIR_HOLD_CYC)
   ) u_seq (
      .clk_i   (clk_i),
      .arst_n_i(seq_arst_n),
      .boot_o  (boot)
   );

   ulpi_gd_sync #(.STAGES(SYNC_STAGES)) u_stp_sync (
      .clk_i   (clk_i),
      .arst_n_i(seq_arst_n),
      .d_i     (stp_i),
      .q_o     (stp_smp)
   );

   assign dir_lvl = boot || phy_turn_i;

   always_comb begin
      drv.dir_oe  = !csel_pd_i;
      drv.nxt_oe  = !csel_pd_i;
      drv.data_oe = !csel_pd_i && !boot && phy_turn_i;
   end

   ulpi_gd_prot #(.DATA_W(DATA_W)) u_prot (
      .clk_i       (clk_i),
      .rst_n_i     (rst_n_i),
      .cfg_we_i    (cfg_we_i),
      .cfg_wdat_i  (cfg_wdat_i),
      .stp_smp_i   (stp_smp),
      .dir_lvl_i   (dir_lvl),
      .xfer_en_i   (xfer_en_i),
      .pd_i        (csel_pd_i),
      .stp_pu_en_o (stp_pu_en_o),
      .data_pd_en_o(data_pd_en_o)
   );

   assign dir_o     = dir_lvl && !csel_pd_i;
   assign dir_oe_o  = drv.dir_oe;
   assign nxt_oe_o  = drv.nxt_oe;
   assign data_oe_o = drv.data_oe;
   assign pd_req_o  = csel_pd_i;
endmodule

// File: rtl/ulpi_gd_chk.sv
module ulpi_gd_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk_i,
   input logic              rst_n_i,
   input logic              csel_pd_i,
   input logic              xfer_en_i,
   input logic              cfg_we_i,
   input logic              cfg_wdat_i,
   input logic              dir_o,
   input logic              dir_oe_o,
   input logic              nxt_oe_o,
   input logic              data_oe_o,
   input logic              stp_pu_en_o,
   input logic [DATA_W-1:0] data_pd_en_o,
   input logic              pd_req_o
);
   always @(negedge clk_i) begin
      if (!rst_n_i && !csel_pd_i)
         AST_RESET_DRIVES_DIR: assert (dir_o && dir_oe_o && !data_oe_o && data_pd_en_o == '0); // R1
      if (csel_pd_i)
         AST_PD_ALL_TRISTATE: assert (!dir_oe_o && !nxt_oe_o && !data_oe_o && pd_req_o
                                      && !stp_pu_en_o && data_pd_en_o == '0); // R8
   end

   AST_PULLDN_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (data_pd_en_o != '0) |-> (!dir_o && !xfer_en_i && !csel_pd_i)); // R5

   AST_PULLDN_UNIFORM: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (data_pd_en_o == '0) || (&data_pd_en_o)); // R5

   AST_DISABLE_TAKES: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (cfg_we_i && cfg_wdat_i) |=> (!stp_pu_en_o && data_pd_en_o == '0)); // R7

   AST_PD_EXIT_DIR_HIGH: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $fell(csel_pd_i) |-> (dir_o && dir_oe_o)); // R9
endmodule

bind ulpi_guard_ctrl ulpi_gd_chk #(.DATA_W(DATA_W)) u_chk (
   .clk_i       (clk_i),
   .rst_n_i     (rst_n_i),
   .csel_pd_i   (csel_pd_i),
   .xfer_en_i   (xfer_en_i),
   .cfg_we_i    (cfg_we_i),
   .cfg_wdat_i  (cfg_wdat_i),
   .dir_o       (dir_o),
   .dir_oe_o    (dir_oe_o),
   .nxt_oe_o    (nxt_oe_o),
   .data_oe_o   (data_oe_o),
   .stp_pu_en_o (stp_pu_en_o),
   .data_pd_en_o(data_pd_en_o),
   .pd_req_o    (pd_req_o)
);

// File: tb/test_ulpi_guard_ctrl.sv
module test_ulpi_guard_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic rst_n, csel_pd, stp, xfer_en, phy_turn, cfg_we, cfg_wdat;
   logic dir, dir_oe, nxt_oe, data_oe, stp_pu, pd_req;
   logic [DW-1:0] data_pd;

   ulpi_guard_ctrl i_ulpi_guard_ctrl (
      .clk_i(clk), .rst_n_i(rst_n), .csel_pd_i(csel_pd), .stp_i(stp),
      .xfer_en_i(xfer_en), .phy_turn_i(phy_turn), .cfg_we_i(cfg_we),
      .cfg_wdat_i(cfg_wdat), .dir_o(dir), .dir_oe_o(dir_oe), .nxt_oe_o(nxt_oe),
      .data_oe_o(data_oe), .stp_pu_en_o(stp_pu), .data_pd_en_o(data_pd),
      .pd_req_o(pd_req)
   );

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] exp_pulldn(logic smp, logic turn, logic xf, logic dis);
      return (smp && !turn && !xf && !dis) ? '1 : '0;
   endfunction

   task automatic nedge(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   // counts rising edges after a release and checks DIR falls after the fourth
   task automatic dir_release(string req);
      for (int k = 1; k <= 4; k++) begin
         nedge(1);
         chk(req, dir, (k < 4) ? 1 : 0);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic m1, m2, dis_m;
      logic r_stp, r_xf, r_turn, r_we, r_wd;
      void'($urandom(32'h1504_5eed));
      rst_n = 0; csel_pd = 0; stp = 0; xfer_en = 0; phy_turn = 0; cfg_we = 0; cfg_wdat = 0;
      nedge(3);
      // R1 reset state
      chk("R1 dir", dir, 1);   chk("R1 dir_oe", dir_oe, 1);  chk("R1 nxt_oe", nxt_oe, 1);
      chk("R1 data_oe", data_oe, 0); chk("R1 pd_req", pd_req, 0);
      chk("R4 pullup default", stp_pu, 1);
      stp = 1; cfg_we = 1; cfg_wdat = 1;
      nedge(3);
      chk("R1 no pulldown in reset", data_pd, 0);
      chk("R3 write ignored in reset", stp_pu, 1);
      stp = 0; cfg_we = 0; cfg_wdat = 0;

      rst_n = 1;
      dir_release("R2 dir release");
      chk("R10 data_oe idle", data_oe, 0);

      phy_turn = 1; #1;
      chk("R10 dir follows turn", dir, 1); chk("R10 data_oe on turn", data_oe, 1);
      phy_turn = 0; #1;
      chk("R10 dir back low", dir, 0);

      // R5 detection latency and gating
      stp = 1;
      nedge(1); chk("R5 one edge", data_pd, 0);
      nedge(1); chk("R5 two edges", data_pd, 8'hFF);
      xfer_en = 1; #1; chk("R5 blocked by transfer", data_pd, 0);
      xfer_en = 0; phy_turn = 1; #1; chk("R5 blocked by dir", data_pd, 0);
      phy_turn = 0; #1; chk("R5 restored", data_pd, 8'hFF);

      // R6 release
      stp = 0;
      nedge(1); chk("R6 still on after one edge", data_pd, 8'hFF);
      nedge(1); chk("R6 off after second edge", data_pd, 0);

      // R7 disable
      stp = 1; nedge(2); chk("R7 pre-disable on", data_pd, 8'hFF);
      cfg_we = 1; cfg_wdat = 1; nedge(1); cfg_we = 0;
      chk("R7 pulldown off", data_pd, 0); chk("R7 pullup off", stp_pu, 0);

      // R3 reset clears disable bit
      rst_n = 0; #1;
      chk("R3 pullup back in reset", stp_pu, 1);
      stp = 0; nedge(2); rst_n = 1;
      dir_release("R2 second release");

      // R8 / R9 power-down
      stp = 1; nedge(2);
      chk("R5 armed before pd", data_pd, 8'hFF);
      csel_pd = 1; #1;
      chk("R8 dir_oe", dir_oe, 0); chk("R8 nxt_oe", nxt_oe, 0); chk("R8 data_oe", data_oe, 0);
      chk("R8 pd_req", pd_req, 1); chk("R8 pullup", stp_pu, 0); chk("R8 pulldown", data_pd, 0);
      stp = 0; nedge(3);
      csel_pd = 0; #1;
      chk("R9 dir on exit", dir, 1); chk("R9 dir_oe on exit", dir_oe, 1);
      dir_release("R9 dir release after pd");

      // random phase (R5 R6 R7 R10)
      nedge(2);
      m1 = 0; m2 = 0; dis_m = 0;
      for (int i = 0; i < 500; i++) begin
         r_stp = 1'($urandom_range(0, 1));
         r_xf = ($urandom_range(0, 3) == 0);
         r_turn = ($urandom_range(0, 4) == 0);
         r_we = ($urandom_range(0, 15) == 0);
         r_wd = 1'($urandom_range(0, 1));
         stp = r_stp; xfer_en = r_xf; phy_turn = r_turn; cfg_we = r_we; cfg_wdat = r_wd;
         nedge(1);
         m2 = m1; m1 = r_stp;
         if (r_we) dis_m = r_wd;
         chk("R5 random pulldown", data_pd, exp_pulldn(m2, r_turn, r_xf, dis_m));
         chk("R7 random pullup", stp_pu, !dis_m);
         chk("R10 random dir", dir, r_turn);
      end
      cfg_we = 0;

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule